// File: doc/BRIEF.md
# Pixel Stream Parallelism Converter

This block changes how many pixels travel together on a pixel stream link. Its input carries `P_IN` pixels per clock and its output carries `P_OUT` pixels per clock. One of the two must be a whole multiple of the other. When the output is wider, consecutive input words are merged into one output word. When the output is narrower, each input word is split into several output words. Pixels keep their scan order, so lane 0 always carries the earliest pixel of a transfer.

Lines and frames stay intact across the width change. Every transfer carries a lane count, an end-of-line flag and an end-of-frame flag. A word is never filled across a line end, so a line whose length is not a multiple of `P_OUT` finishes with a partial word. A line with no pixels comes out as a single transfer with a count of zero and the line flag set.

Both sides use a valid/ready handshake on one clock. A stall at the output stops the input, so backpressure reaches the upstream stage. The block holds at most one word.

Top module: `pix_par_conv`

## Requirements
- R1: Output pixels appear in the same order as input pixels. Lane k sits at data bits [k*PIX_W +: PIX_W], and lane 0 holds the earliest pixel of a word.
- R2: Words that are not the last of a line carry exactly `P_OUT` pixels. When widening, `P_OUT/P_IN` full input words form one output word. When narrowing, one full input word becomes `P_IN/P_OUT` output words. The output count never exceeds `P_OUT`.
- R3: The last word of a line with L > 0 pixels has count ((L-1) mod `P_OUT`)+1 and has `out_eol` set. No output word holds pixels from two lines, and a word with count below `P_OUT` always has `out_eol` set.
- R4: An input transfer with count 0 and the line flag set (an empty line) produces exactly one output transfer with count 0 and `out_eol` set.
- R5: The input may raise `in_eof` only together with `in_eol`. `out_eof` is set only on the word that ends the frame's last line, and always together with `out_eol`.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high, with data, count and flags unchanged.
- R8: A synchronous active-high reset clears `out_valid` and discards any partly packed or partly sent word. After reset, `in_ready` is high.
- R9: When widening with `out_ready` held high, `in_ready` never drops, so the input streams without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_data | input | P_IN*PIX_W | Input pixels, lane 0 in the low bits |
| in_cnt | input | $clog2(P_IN+1) | Number of valid input lanes; below P_IN only with in_eol |
| in_eol | input | 1 | Input word ends a line |
| in_eof | input | 1 | Input word ends a frame (only with in_eol) |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | P_OUT*PIX_W | Output pixels, lane 0 in the low bits |
| out_cnt | output | $clog2(P_OUT+1) | Number of valid output lanes |
| out_eol | output | 1 | Output word ends a line |
| out_eof | output | 1 | Output word ends a frame |

## Verification
The bench runs two instances, one widening 2 to 4 lanes and one narrowing 4 to 2 lanes. Both receive a mix of lines of lengths 0, 1, 2, 3, 4, 5, 6, 7 and 8, first with the output always ready and then with a pseudo-random stall pattern.

Each corner case catches a specific kind of bug:
- A design that packs across a line end merges the 3-pixel line with the following line and shifts every later pixel.
- A design that drops empty lines loses the zero-count transfer.
- A design that takes input during a stall changes held data or loses words.
- A reset that keeps the partial word would emit a stale 3-pixel word, where only the fresh 1-pixel line is expected.

// File: rtl/pix_par_pkg.sv
package pix_par_pkg;

  // Width of a lane count able to hold the values 0..lanes.
  function automatic int cnt_bits(input int lanes);
    return $clog2(lanes + 1);
  endfunction

  // Width of a slot index for n slots (at least one bit).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pix_pack.sv
// Widening path: merges P_OUT/P_IN input words into one output word.
// The output register itself is the packing buffer.
module pix_pack
  import pix_par_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int P_IN  = 2,
  parameter int P_OUT = 4,
  localparam int IW    = P_IN * PIX_W,
  localparam int OW    = P_OUT * PIX_W,
  localparam int CI    = cnt_bits(P_IN),
  localparam int CO    = cnt_bits(P_OUT),
  localparam int SLOTS = P_OUT / P_IN,
  localparam int SW    = idx_bits(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_data,
  input  logic [CI-1:0] in_cnt,
  input  logic          in_eol,
  input  logic          in_eof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic [CO-1:0] out_cnt,
  output logic          out_eol,
  output logic          out_eof
);

  logic          vld_q, eol_q, eof_q;
  logic [CO-1:0] fill_q;
  logic [OW-1:0] data_q;
  logic [CO-1:0] base, sum;
  logic [SW-1:0] slot;
  logic          take, done;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    base = vld_q ? '0 : fill_q;          // a draining word frees the register
    sum  = base + CO'(in_cnt);
    slot = SW'(base / CO'(P_IN));
    done = in_eol || (sum == CO'(P_OUT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      eol_q  <= 1'b0;
      eof_q  <= 1'b0;
      fill_q <= '0;
    end else if (take) begin
      fill_q <= sum;
      vld_q  <= done;
      eol_q  <= in_eol;
      eof_q  <= in_eol && in_eof;
    end else if (vld_q && out_ready) begin
      vld_q  <= 1'b0;
      fill_q <= '0;
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (take && slot == SW'(k)) data_q[k*IW +: IW] <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_cnt   = fill_q;
  assign out_eol   = eol_q;
  assign out_eof   = eof_q;

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cnt)
      && $stable(out_eol) && $stable(out_eof));
  assert_partial_ends_line_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cnt != CO'(P_OUT) |-> out_eol);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cnt <= CO'(P_OUT));
  assert_eof_on_eol_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eof |-> out_eol);
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/pix_unpack.sv
// Narrowing path: holds one input word and emits it P_OUT lanes at a time.
module pix_unpack
  import pix_par_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int P_IN  = 4,
  parameter int P_OUT = 2,
  localparam int IW    = P_IN * PIX_W,
  localparam int OW    = P_OUT * PIX_W,
  localparam int CI    = cnt_bits(P_IN),
  localparam int CO    = cnt_bits(P_OUT),
  localparam int SLOTS = P_IN / P_OUT,
  localparam int SW    = idx_bits(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_data,
  input  logic [CI-1:0] in_cnt,
  input  logic          in_eol,
  input  logic          in_eof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic [CO-1:0] out_cnt,
  output logic          out_eol,
  output logic          out_eof
);

  logic          vld_q, eol_q, eof_q;
  logic [IW-1:0] data_q;
  logic [CI-1:0] rem_q;
  logic [SW-1:0] slot_q;
  logic          last;
  logic [OW-1:0] part [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_part
    assign part[k] = data_q[k*OW +: OW];
  end

  assign last     = rem_q <= CI'(P_OUT);
  assign in_ready = !vld_q || (out_ready && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      eol_q  <= 1'b0;
      eof_q  <= 1'b0;
      rem_q  <= '0;
      slot_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q  <= 1'b1;
      data_q <= in_data;
      rem_q  <= in_cnt;
      slot_q <= '0;
      eol_q  <= in_eol;
      eof_q  <= in_eol && in_eof;
    end else if (vld_q && out_ready) begin
      if (last) begin
        vld_q <= 1'b0;
      end else begin
        slot_q <= slot_q + 1'b1;
        rem_q  <= rem_q - CI'(P_OUT);
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = part[slot_q];
  assign out_cnt   = last ? CO'(rem_q) : CO'(P_OUT);
  assign out_eol   = eol_q && last;
  assign out_eof   = eof_q && last;

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cnt)
      && $stable(out_eol) && $stable(out_eof));
  assert_partial_ends_line_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cnt != CO'(P_OUT) |-> out_eol);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cnt <= CO'(P_OUT));
  assert_eof_on_eol_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eof |-> out_eol);
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/pix_par_conv.sv
module pix_par_conv
  import pix_par_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int P_IN  = 2,
  parameter int P_OUT = 4,
  localparam int IW = P_IN * PIX_W,
  localparam int OW = P_OUT * PIX_W,
  localparam int CI = cnt_bits(P_IN),
  localparam int CO = cnt_bits(P_OUT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_data,
  input  logic [CI-1:0] in_cnt,
  input  logic          in_eol,
  input  logic          in_eof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic [CO-1:0] out_cnt,
  output logic          out_eol,
  output logic          out_eof
);

  if (P_OUT >= P_IN) begin : g_widen
    pix_pack #(.PIX_W(PIX_W), .P_IN(P_IN), .P_OUT(P_OUT)) u_pack (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_cnt(in_cnt), .in_eol(in_eol), .in_eof(in_eof),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_cnt(out_cnt), .out_eol(out_eol), .out_eof(out_eof));
  end else begin : g_narrow
    pix_unpack #(.PIX_W(PIX_W), .P_IN(P_IN), .P_OUT(P_OUT)) u_unpack (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_cnt(in_cnt), .in_eol(in_eol), .in_eof(in_eof),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_cnt(out_cnt), .out_eol(out_eol), .out_eof(out_eof));
  end

endmodule

// File: tb/sim_pix_par_conv.sv
`timescale 1ns/1ps
module sim_pix_par_conv;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // u0: widen 2 -> 4 lanes
  logic        iv0 = 1'b0, ir0, ie0 = 1'b0, if0 = 1'b0;
  logic [15:0] id0 = '0;
  logic [1:0]  ic0 = '0;
  logic        ov0, or0 = 1'b1, oe0, of0;
  logic [31:0] od0;
  logic [2:0]  oc0;
  // u1: narrow 4 -> 2 lanes
  logic        iv1 = 1'b0, ir1, ie1 = 1'b0, if1 = 1'b0;
  logic [31:0] id1 = '0;
  logic [2:0]  ic1 = '0;
  logic        ov1, or1 = 1'b1, oe1, of1;
  logic [15:0] od1;
  logic [1:0]  oc1;

  pix_par_conv #(.PIX_W(8), .P_IN(2), .P_OUT(4)) u0 (
    .clk(clk), .rst(rst), .in_valid(iv0), .in_ready(ir0), .in_data(id0),
    .in_cnt(ic0), .in_eol(ie0), .in_eof(if0), .out_valid(ov0), .out_ready(or0),
    .out_data(od0), .out_cnt(oc0), .out_eol(oe0), .out_eof(of0));

  pix_par_conv #(.PIX_W(8), .P_IN(4), .P_OUT(2)) u1 (
    .clk(clk), .rst(rst), .in_valid(iv1), .in_ready(ir1), .in_data(id1),
    .in_cnt(ic1), .in_eol(ie1), .in_eof(if1), .out_valid(ov1), .out_ready(or1),
    .out_data(od1), .out_cnt(oc1), .out_eol(oe1), .out_eof(of1));

  // Stimulus table: line length, frame end, expected word counts at 4 and 2 lanes.
  localparam int NL = 9;
  localparam int LEN  [NL] = '{3, 0, 4, 8, 1, 5, 2, 7, 6};
  localparam bit EOFL [NL] = '{0, 0, 0, 0, 0, 1, 0, 0, 1};
  localparam int EXP4 [NL] = '{1, 1, 1, 2, 1, 2, 1, 2, 2};
  localparam int EXP2 [NL] = '{2, 1, 2, 4, 1, 3, 1, 4, 3};

  typedef struct packed {
    logic        eof;
    logic        eol;
    logic [2:0]  cnt;
    logic [31:0] pix;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int checks = 0, errors = 0;
  int wc0 = 0, wc1 = 0, stall0 = 0;
  int mode0 = 0, mode1 = 0;   // 0 always ready, 1 pseudo-random, 2 never ready
  logic [7:0] lf0 = 8'h5a, lf1 = 8'hc3;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build(input int which);
    int s = 0;
    int pout = (which == 0) ? 4 : 2;
    for (int l = 0; l < NL; l++) begin
      if (LEN[l] == 0) begin
        exp_t e = '{eof: EOFL[l], eol: 1'b1, cnt: 3'd0, pix: 32'd0};
        if (which == 0) q0.push_back(e); else q1.push_back(e);
      end else begin
        for (int i = 0; i < LEN[l]; i += pout) begin
          int n = (LEN[l] - i < pout) ? LEN[l] - i : pout;
          exp_t e;
          e.pix = '0;
          for (int k = 0; k < n; k++) e.pix[k*8 +: 8] = 8'(s + i + k);
          e.cnt = 3'(n);
          e.eol = (i + n == LEN[l]);
          e.eof = EOFL[l] && (i + n == LEN[l]);
          if (which == 0) q0.push_back(e); else q1.push_back(e);
        end
      end
      s += LEN[l];
    end
  endtask

  task automatic take_word(input int which, input logic [31:0] d, input int c,
                           input logic eol, input logic eof);
    exp_t e;
    if ((which == 0 && q0.size() == 0) || (which == 1 && q1.size() == 0)) begin
      chk(0, "R1", "unexpected output word", longint'(d), 0);
      return;
    end
    e = (which == 0) ? q0.pop_front() : q1.pop_front();
    chk(c == int'(e.cnt), (e.cnt == 0) ? "R4" : (e.eol ? "R3" : "R2"),
        "lane count", c, e.cnt);
    chk(eol == e.eol, "R3", "end of line", eol, e.eol);
    chk(eof == e.eof, "R5", "end of frame", eof, e.eof);
    for (int k = 0; k < int'(e.cnt); k++)
      chk(d[k*8 +: 8] == e.pix[k*8 +: 8], "R1", "pixel lane", d[k*8 +: 8], e.pix[k*8 +: 8]);
  endtask

  // Output monitors: set ready at the falling edge, sample before the rising edge.
  logic        st0 = 0, st1 = 0;
  logic [36:0] pv0, pv1;
  always begin
    @(negedge clk);
    lf0 = {lf0[6:0], lf0[7] ^ lf0[5] ^ lf0[4] ^ lf0[3]};
    or0 = (mode0 == 0) ? 1'b1 : (mode0 == 2) ? 1'b0 : lf0[0];
    #2;
    if (rst) st0 = 0;
    else begin
      if (st0) chk(ov0 && pv0 == {of0, oe0, oc0, od0}, "R7", "held word changed",
                   {ov0, of0, oe0, oc0, od0}, {1'b1, pv0});
      if (ov0 && !or0) chk(!ir0, "R6", "in_ready during stall", ir0, 0);
      if (ov0 && or0) begin wc0++; take_word(0, od0, oc0, oe0, of0); end
      st0 = ov0 && !or0;
      pv0 = {of0, oe0, oc0, od0};
    end
  end
  always begin
    @(negedge clk);
    lf1 = {lf1[6:0], lf1[7] ^ lf1[5] ^ lf1[4] ^ lf1[3]};
    or1 = (mode1 == 0) ? 1'b1 : (mode1 == 2) ? 1'b0 : lf1[0];
    #2;
    if (rst) st1 = 0;
    else begin
      if (st1) chk(ov1 && pv1 == {of1, oe1, 1'b0, oc1, 16'h0, od1}, "R7", "held word changed",
                   {ov1, of1, oe1, oc1, od1}, {1'b1, pv1});
      if (ov1 && !or1) chk(!ir1, "R6", "in_ready during stall", ir1, 0);
      if (ov1 && or1) begin wc1++; take_word(1, {16'h0, od1}, oc1, oe1, of1); end
      st1 = ov1 && !or1;
      pv1 = {of1, oe1, 1'b0, oc1, 16'h0, od1};
    end
  end

  task automatic send0(input int n, input logic [15:0] d, input bit eol, input bit eof);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      iv0 = 1; id0 = d; ic0 = 2'(n); ie0 = eol; if0 = eof;
      #1;
      acc = ir0;
      if (!acc && mode0 == 0) stall0++;
      @(posedge clk);
    end
  endtask

  task automatic send1(input int n, input logic [31:0] d, input bit eol, input bit eof);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      iv1 = 1; id1 = d; ic1 = 3'(n); ie1 = eol; if1 = eof;
      #1;
      acc = ir1;
      @(posedge clk);
    end
  endtask

  task automatic stream0();
    int s = 0;
    for (int l = 0; l < NL; l++) begin
      if (LEN[l] == 0) send0(0, 16'h0, 1, EOFL[l]);
      else for (int i = 0; i < LEN[l]; i += 2) begin
        int n = (LEN[l] - i < 2) ? LEN[l] - i : 2;
        logic [15:0] d = '0;
        for (int k = 0; k < n; k++) d[k*8 +: 8] = 8'(s + i + k);
        send0(n, d, i + n == LEN[l], EOFL[l] && (i + n == LEN[l]));
      end
      s += LEN[l];
    end
    @(negedge clk); iv0 = 0;
  endtask

  task automatic stream1();
    int s = 0;
    for (int l = 0; l < NL; l++) begin
      if (LEN[l] == 0) send1(0, 32'h0, 1, EOFL[l]);
      else for (int i = 0; i < LEN[l]; i += 4) begin
        int n = (LEN[l] - i < 4) ? LEN[l] - i : 4;
        logic [31:0] d = '0;
        for (int k = 0; k < n; k++) d[k*8 +: 8] = 8'(s + i + k);
        send1(n, d, i + n == LEN[l], EOFL[l] && (i + n == LEN[l]));
      end
      s += LEN[l];
    end
    @(negedge clk); iv1 = 0;
  endtask

  task automatic drain();
    int t = 0;
    while ((q0.size() != 0 || q1.size() != 0) && t < 3000) begin
      @(posedge clk); t++;
    end
    chk(q0.size() == 0, "R2", "widen words missing", q0.size(), 0);
    chk(q1.size() == 0, "R2", "narrow words missing", q1.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int sum4 = 0, sum2 = 0;
    for (int l = 0; l < NL; l++) begin sum4 += EXP4[l]; sum2 += EXP2[l]; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(!ov0 && ir0, "R8", "u0 reset state", {ov0, ir0}, 2'b01);
    chk(!ov1 && ir1, "R8", "u1 reset state", {ov1, ir1}, 2'b01);

    // Phase A: always ready
    build(0); build(1);
    wc0 = 0; wc1 = 0; stall0 = 0;
    fork stream0(); stream1(); join
    drain();
    chk(wc0 == sum4, "R2", "widen word total", wc0, sum4);
    chk(wc1 == sum2, "R2", "narrow word total", wc1, sum2);
    chk(stall0 == 0, "R9", "widen input stalls", stall0, 0);

    // Phase B: pseudo-random backpressure
    mode0 = 1; mode1 = 1;
    build(0); build(1);
    wc0 = 0; wc1 = 0;
    fork stream0(); stream1(); join
    drain();
    chk(wc0 == sum4, "R6", "widen word total under stall", wc0, sum4);
    chk(wc1 == sum2, "R6", "narrow word total under stall", wc1, sum2);
    mode0 = 0; mode1 = 0;
    repeat (4) @(negedge clk);

    // R8: partial packed word in u0 is dropped by reset
    send0(2, 16'hbbaa, 0, 0);
    @(negedge clk); iv0 = 0; rst = 1;
    @(negedge clk); rst = 0;
    #1;
    chk(!ov0, "R8", "u0 valid after reset", ov0, 0);
    q0.push_back('{eof: 1'b0, eol: 1'b1, cnt: 3'd1, pix: 32'h000000cc});
    send0(1, 16'h00cc, 1, 0);
    @(negedge clk); iv0 = 0;
    drain();

    // R8: word held in u1 under stall is dropped by reset
    mode1 = 2;
    repeat (2) @(negedge clk);
    send1(4, 32'h44332211, 1, 1);
    @(negedge clk); iv1 = 0;
    #1;
    chk(ov1, "R7", "u1 holds word while stalled", ov1, 1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    #1;
    chk(!ov1 && ir1, "R8", "u1 state after reset", {ov1, ir1}, 2'b01);
    wc1 = 0;
    mode1 = 0;
    repeat (6) @(negedge clk);
    chk(wc1 == 0, "R8", "u1 words after reset", wc1, 0);

    finish_run();
  end

endmodule